// File: doc/BRIEF.md
# Write-only two-wire control slave

This block is a receive-only slave on a two-wire serial bus (one clock line, one data line). It holds a small bank of output-enable bytes that a bus master loads. A system clock much faster than the bus samples both lines. The block detects start and stop conditions and checks that the first byte carries its write address. It acknowledges each byte that belongs to its own transfer. The block never drives data back to the master and has no readback path. Its only way of influencing the bus is an open-drain pull-down on the data line, used for acknowledges.

After the address, every transfer must carry two header bytes: a command byte, then a count byte. Both are acknowledged and their contents are discarded. Every byte after these goes into the enable bank. The first data byte lands in the first enable byte, the next byte in the second, and so on. The block has no subaddress, so to change a later byte the master must also resend every byte in front of it. Once the bank is full, any further bytes are acknowledged and thrown away.

The control state machine has these states: S_IDLE (bus free), S_ADDR (shifting the address byte), S_ADDR_ACK, S_CMD, S_CMD_ACK, S_CNT, S_CNT_ACK, S_DATA, S_DATA_ACK, and S_SKIP (ignoring a transfer meant for another device or for a read).

- A start from any state moves to S_ADDR. A stop moves to S_IDLE.
- S_ADDR moves to S_ADDR_ACK on the falling edge after the eighth bit if the byte matches the write address. Otherwise it moves to S_SKIP.
- Each receive state moves to its ACK state on the falling edge after the eighth bit.
- Each ACK state moves to the next receive state on the falling edge after the ninth pulse: S_ADDR_ACK to S_CMD, S_CMD_ACK to S_CNT, S_CNT_ACK to S_DATA, and S_DATA_ACK back to S_DATA.

Top module: `ctl2w_slave`

## Requirements
- R1: After reset, every bit of `en_vec` is 1 (all outputs enabled) and `sda_pull` is 0.
- R2: A start condition (data falls while clock is high) restarts address reception from any state, including in the middle of a transfer. A stop condition (data rises while clock is high) returns the block to idle and releases the data line.
- R3: When the address byte is 0xD2 (7-bit address 0x69 with direction bit 0 = write), the block drives `sda_pull` high from the clock falling edge after the eighth bit until the clock falling edge after the ninth pulse. The line is therefore low for the whole ninth pulse.
- R4: An address byte with the direction bit set to 1 (for example 0xD3), or with any other address, gets no acknowledge. The bytes that follow in that transfer get no acknowledge and change no register, until the next start.
- R5: The command byte and the count byte after the address are both acknowledged. Whatever values they carry, `en_vec` is left unchanged.
- R6: Data bytes arrive most significant bit first. The first data byte is stored in `en_vec[7:0]`, where bit k enables output k+8. The second is stored in `en_vec[15:8]`, where bit 15 enables output 17, bit 14 enables output 16, and bits 13..8 are reserved bits that are stored as written.
- R7: Data bytes beyond the last enable byte are acknowledged and discarded.
- R8: A transfer that ends after fewer data bytes than the bank holds leaves the remaining bytes unchanged. A repeated start sends the next data byte back to `en_vec[7:0]`.
- R9: A stop in the middle of a byte stores nothing from that partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 = pull the data line low (open-drain acknowledge) |
| en_vec | output | 16 (NREG*8) | Enable bank; byte n holds the n-th data byte of a transfer |

## Verification
A behavioural bus master drives bit-level waveforms. A bench model follows the transfer phase and predicts the enable bank and the acknowledge line. Both are compared on every clock once the lines have been quiet for long enough to pass the synchronizers.

The patterns are chosen to separate cases that a single write could not tell apart:
- Header bytes with nonzero contents show that the command and count bytes are not mistaken for data.
- Three data bytes in one transfer show whether the first and second bytes land in the right place and whether the extra byte is dropped.
- A read address and a foreign address show that nothing is acknowledged or stored in either case.
- A short write followed by a stop shows that a partial update leaves the second byte alone.
- A repeated start inside a write shows that the sequence returns to the first byte.
- A stop cut into a byte shows that the partial byte is thrown away.

// File: rtl/ctl2w_pkg.sv
package ctl2w_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_CMD,
        S_CMD_ACK,
        S_CNT,
        S_CNT_ACK,
        S_DATA,
        S_DATA_ACK,
        S_SKIP
    } ctl2w_state_e;

endpackage

// File: rtl/ctl2w_sync.sv
module ctl2w_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int NLINE = 2;
    localparam int L_SDA = 0;
    localparam int L_SCL = 1;

    logic [NLINE-1:0] raw;
    logic [NLINE-1:0] cur;
    logic [NLINE-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[l]};
        end
        assign cur[l] = chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= cur;
    end

    assign sda_s     = cur[L_SDA];
    assign scl_rise  =  cur[L_SCL] & ~prev[L_SCL];
    assign scl_fall  = ~cur[L_SCL] &  prev[L_SCL];
    assign start_evt =  cur[L_SCL] &  prev[L_SCL] &  prev[L_SDA] & ~cur[L_SDA];
    assign stop_evt  =  cur[L_SCL] &  prev[L_SCL] & ~prev[L_SDA] &  cur[L_SDA];

endmodule

// File: rtl/ctl2w_fsm.sv
module ctl2w_fsm
    import ctl2w_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREG     = 2,
    parameter int         IDXW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [IDXW-1:0]   wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [BYTE_W-1:0] WR_HDR    = {DEV_ADDR, 1'b0};
    localparam logic [3:0]        BITS_LAST = 4'(BYTE_W);
    localparam logic [3:0]        ACK_HI    = 4'(BYTE_W + 1);
    localparam logic [IDXW-1:0]   IDX_END   = IDXW'(NREG);

    ctl2w_state_e      state, state_n;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] sh;
    logic [IDXW-1:0]   idx;
    logic              byte_done, ack_done, in_rx, in_ack;

    assign byte_done = scl_fall && (bitcnt == BITS_LAST);
    assign ack_done  = scl_fall && (bitcnt == ACK_HI);
    assign in_rx     = state inside {S_ADDR, S_CMD, S_CNT, S_DATA};
    assign in_ack    = state inside {S_ADDR_ACK, S_CMD_ACK, S_CNT_ACK, S_DATA_ACK};

    // next-state decision
    always_comb begin
        state_n = state;
        if (start_evt) begin
            state_n = S_ADDR;
        end else if (stop_evt) begin
            state_n = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE, S_SKIP: state_n = state;
                S_ADDR:     if (byte_done) state_n = (sh == WR_HDR) ? S_ADDR_ACK : S_SKIP;
                S_ADDR_ACK: if (ack_done)  state_n = S_CMD;
                S_CMD:      if (byte_done) state_n = S_CMD_ACK;
                S_CMD_ACK:  if (ack_done)  state_n = S_CNT;
                S_CNT:      if (byte_done) state_n = S_CNT_ACK;
                S_CNT_ACK:  if (ack_done)  state_n = S_DATA;
                S_DATA:     if (byte_done) state_n = S_DATA_ACK;
                S_DATA_ACK: if (ack_done)  state_n = S_DATA;
                default:    state_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // bit counter, shifter, register index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= '0;
            sh     <= '0;
            idx    <= '0;
        end else if (start_evt || stop_evt) begin
            bitcnt <= '0;
            idx    <= '0;
        end else begin
            if (ack_done) begin
                bitcnt <= '0;
            end else if (scl_rise && in_rx && (bitcnt < BITS_LAST)) begin
                sh     <= {sh[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
            end else if (scl_rise && in_ack) begin
                bitcnt <= ACK_HI;
            end
            if ((state == S_DATA) && byte_done && (idx != IDX_END))
                idx <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        wr_en    = 1'b0;
        unique case (state)
            S_ADDR_ACK, S_CMD_ACK, S_CNT_ACK, S_DATA_ACK: sda_pull = 1'b1;
            S_DATA: wr_en = byte_done && !start_evt && !stop_evt && (idx != IDX_END);
            default: ;
        endcase
    end

    assign wr_idx  = idx;
    assign wr_data = sh;

    AST_PULL_BEGINS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall)); // R3
    AST_PULL_ENDS_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> $past(scl_fall || start_evt || stop_evt)); // R3
    AST_STOP_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> (state == S_IDLE) && !sda_pull); // R2
    AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == S_ADDR) && (bitcnt == 4'd0)); // R2
    AST_READ_NOT_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_ADDR) && byte_done && sh[0]) |=> !sda_pull); // R4

endmodule

// File: rtl/ctl2w_regs.sv
module ctl2w_regs
    import ctl2w_pkg::*;
#(
    parameter int NREG = 2,
    parameter int IDXW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDXW-1:0]        wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    output logic [NREG*BYTE_W-1:0] en_vec
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_vec[g*BYTE_W +: BYTE_W] <= '1;
            else if (wr_en && (wr_idx == IDXW'(g)))
                en_vec[g*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    AST_BANK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(en_vec) |-> $past(wr_en)); // R5

endmodule

// File: rtl/ctl2w_slave.sv
module ctl2w_slave
    import ctl2w_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NREG        = 2,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_pull,
    output logic [NREG*BYTE_W-1:0] en_vec
);
    localparam int IDXW = $clog2(NREG + 1);

    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              wr_en;
    logic [IDXW-1:0]   wr_idx;
    logic [BYTE_W-1:0] wr_data;

    ctl2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    ctl2w_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .IDXW(IDXW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .sda_pull(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    ctl2w_regs #(.NREG(NREG), .IDXW(IDXW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .en_vec(en_vec)
    );

endmodule

// File: tb/sim_ctl2w_slave.sv
`timescale 1ns/1ps
module sim_ctl2w_slave;
    localparam int H = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_pull;
    logic [15:0] en_vec;

    int          cyc = 0;
    int          last_chg = 0;
    int          ntot = 0;
    int          nbad = 0;
    bit          done = 0;

    logic [15:0] exp_en = 16'hFFFF;
    bit          exp_pull = 0;
    int          mphase = 0;   // 0 idle,1 addr,2 cmd,3 count,4 data,5 skip
    int          midx = 0;

    assign sda_line = sda_m & ~sda_pull;

    ctl2w_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull(sda_pull), .en_vec(en_vec)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        ntot++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference comparison on every settled clock
    always @(negedge clk) begin
        if (rst_n && !done && (cyc - last_chg) >= 8) begin
            chk(en_vec == exp_en, "R6 bank vs model", int'(en_vec), int'(exp_en));
            chk(sda_pull == exp_pull, "R3 pull vs model", int'(sda_pull), int'(exp_pull));
        end
    end

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic s, input logic d);
        scl_m = s;
        sda_m = d;
        last_chg = cyc;
    endtask

    task automatic model_byte(input logic [7:0] b);
        case (mphase)
            1: if (b == 8'hD2) begin mphase = 2; exp_pull = 1; end
               else mphase = 5;
            2: begin mphase = 3; exp_pull = 1; end
            3: begin mphase = 4; exp_pull = 1; end
            4: begin
                exp_pull = 1;
                if (midx < 2) exp_en[midx*8 +: 8] = b;
                midx++;
            end
            default: ;
        endcase
    endtask

    task automatic bus_start;
        if (!scl_m) begin drive(1'b0, 1'b1); hold(H/2); end
        drive(1'b1, 1'b1); hold(H);
        drive(1'b1, 1'b0); mphase = 1; midx = 0; exp_pull = 0; hold(H);
        drive(1'b0, 1'b0); hold(H/2);
    endtask

    task automatic bus_stop;
        drive(1'b0, 1'b0); hold(H/2);
        drive(1'b1, 1'b0); hold(H);
        drive(1'b1, 1'b1); mphase = 0; exp_pull = 0; hold(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            drive(1'b0, sda_m); hold(H/2);
            drive(1'b0, b[i]);  hold(H/2);
            drive(1'b1, b[i]);  hold(H);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        drive(1'b0, sda_m); model_byte(b); hold(H/2);
        drive(1'b0, 1'b1); hold(H/2);
        drive(1'b1, 1'b1); hold(H - 2);
        acked = (sda_line == 1'b0);
        hold(2);
        drive(1'b0, 1'b1); exp_pull = 0; hold(H);
    endtask

    initial begin
        bit a;
        hold(6);
        rst_n = 1'b1;
        hold(10);
        chk(en_vec == 16'hFFFF, "R1 reset bank", int'(en_vec), 16'hFFFF);
        chk(sda_pull == 1'b0, "R1 reset pull", int'(sda_pull), 0);

        // full write with extra byte
        bus_start();
        send_byte(8'hD2, a); chk(a, "R3 address ack", int'(a), 1);
        send_byte(8'h5A, a); chk(a, "R5 command ack", int'(a), 1);
        send_byte(8'hC3, a); chk(a, "R5 count ack", int'(a), 1);
        chk(en_vec == 16'hFFFF, "R5 header leaves bank", int'(en_vec), 16'hFFFF);
        send_byte(8'hA5, a); chk(en_vec[7:0] == 8'hA5, "R6 first data byte", int'(en_vec[7:0]), 8'hA5);
        send_byte(8'h3C, a); chk(en_vec[15:8] == 8'h3C, "R6 second data byte", int'(en_vec[15:8]), 8'h3C);
        send_byte(8'h00, a); chk(a, "R7 extra byte ack", int'(a), 1);
        chk(en_vec == 16'h3CA5, "R7 extra byte discarded", int'(en_vec), 16'h3CA5);
        bus_stop();
        chk(sda_pull == 1'b0, "R2 stop releases", int'(sda_pull), 0);

        // read direction
        bus_start();
        send_byte(8'hD3, a); chk(!a, "R4 read address no ack", int'(a), 0);
        send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h00, a); chk(!a, "R4 skipped byte no ack", int'(a), 0);
        chk(en_vec == 16'h3CA5, "R4 read leaves bank", int'(en_vec), 16'h3CA5);
        bus_stop();

        // foreign address, then repeated start to own address
        bus_start();
        send_byte(8'hA0, a); chk(!a, "R4 foreign address no ack", int'(a), 0);
        bus_start();
        send_byte(8'hD2, a); chk(a, "R2 restart leaves skip", int'(a), 1);
        send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h0F, a);
        bus_stop();
        chk(en_vec == 16'h3C0F, "R8 short write keeps byte 2", int'(en_vec), 16'h3C0F);

        // repeated start inside a data phase
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h11, a); send_byte(8'h22, a);
        send_byte(8'h11, a);
        bus_start();
        send_byte(8'hD2, a); send_byte(8'hFF, a); send_byte(8'hFF, a);
        send_byte(8'h22, a);
        chk(en_vec == 16'h3C22, "R8 restart returns to byte 1", int'(en_vec), 16'h3C22);
        bus_stop();

        // stop in the middle of a data byte
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_bits(8'h00, 5);
        bus_stop();
        chk(en_vec == 16'h3C22, "R9 partial byte dropped", int'(en_vec), 16'h3C22);

        hold(20);
        done = 1;
        $display("test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            ntot++;
            nbad++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", ntot, nbad);
            $finish;
        end
    end

endmodule